// File: doc/BRIEF.md
# Address-Aliased Cache Mode Line Guard

This block sits on a 32-bit processor address path in front of memory. Two upper address bits act as a cache-mode selector. Software picks the caching behaviour of an access by choosing which alias of a location it uses. The block decodes those two bits into a cache mode, then drops them from the address. Memory therefore sees one 1-Gbyte space that appears four times in the processor map.

Software can reach the same 16-byte line through both a cachable alias and the inhibited alias. A copy held in the cache could then later overwrite data written around it. To catch this, the block keeps a small direct-mapped record of the mode last used on each tracked line. It raises a violation flag when a cache-inhibited access lands on a line whose record is cachable. A push or invalidate strobe for a line removes that line's record. The block only decodes, mirrors and checks; it never blocks an access.

Top module: `cmode_line_guard`

## Requirements
- R1: `mode_o` decodes the code {acc_addr[MODE_BIT_A], acc_addr[MODE_BIT_B]} combinationally. Code 00 gives 0 (inhibited, serialized), 01 gives 1 (copyback), and 10 or 11 give 2 (write-through).
- R2: MODE_BIT_A and MODE_BIT_B are parameters that may take any distinct values in 31..24, adjacent or not. Any other setting stops elaboration with an error.
- R3: `mem_addr_o` is `acc_addr` with the two mode bits removed. The other 30 bits keep their relative order, and the result is combinational.
- R4: Tracking is per 16-byte line, and the line number is mem_addr_o[29:4]. Accesses to different words of one line share one record.
- R5: A valid inhibited access to a line whose record holds copyback or write-through drives `viol_o` high for exactly the next cycle. The record stays unchanged.
- R6: A `maint_valid` strobe with `maint_line` equal to a line's number clears that line's record. A later inhibited access to the line then raises no violation.
- R7: A cachable access to a line recorded as inhibited raises no violation and replaces the record with the new mode.
- R8: The table is direct-mapped with ENTRIES entries, indexed by the low bits of the line number. An access to a line with no matching record raises no violation and takes over the entry.
- R9: When a strobe and an access name the same line in the same cycle, the strobe wins. There is no violation, and the access leaves no record.
- R10: Under synchronous reset `viol_o` is 0 and every record is invalid.
- R11: `viol_o` is registered and is high only in the cycle after a valid access. A cycle with `acc_valid` low changes no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present on `acc_addr` |
| acc_addr | input | 32 | Processor byte address, mode bits included |
| maint_valid | input | 1 | Push or invalidate of one line |
| maint_line | input | 26 | Mirrored line number of the push or invalidate |
| mode_o | output | 2 | Decoded cache mode (0 inhibited, 1 copyback, 2 write-through) |
| mem_addr_o | output | 30 | Mirrored memory byte address |
| viol_o | output | 1 | Mixed-mode line access seen in the previous cycle |

## Verification
The bench sets the mode bits at positions 27 and 25. These are neither adjacent nor at the top of the field, so the bit-removal logic must close two separate gaps in the address. It uses an 8-entry table and draws accesses from a pool of twelve lines. That pool forces frequent index conflicts, so records are often evicted and many accesses land on untracked lines. Directed sequences cover the violation, clearing after a strobe, the inhibited-to-cachable change, eviction, and a strobe and access to the same line in one cycle.

// File: rtl/cmg_pkg.sv
package cmg_pkg;
  localparam int ADDR_W = 32;
  localparam int MEM_W  = 30;
  localparam int OFS_W  = 4;
  localparam int LINE_W = MEM_W - OFS_W;

  typedef enum logic [1:0] {
    CM_INHIBIT  = 2'd0,
    CM_COPYBACK = 2'd1,
    CM_WRTHRU   = 2'd2
  } cmode_e;

  // Processor address bit that feeds mirrored bit i once the two
  // selector positions a and b are skipped.
  function automatic int src_bit(input int i, input int a, input int b);
    int lo;
    int hi;
    int j;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    j  = i;
    if (j >= lo) j = j + 1;
    if (j >= hi) j = j + 1;
    return j;
  endfunction
endpackage

// File: rtl/cmg_decode.sv
module cmg_decode
  import cmg_pkg::*;
#(
  parameter int MODE_BIT_A = 31,
  parameter int MODE_BIT_B = 30
) (
  input  logic [ADDR_W-1:0] addr,
  output cmode_e            mode,
  output logic [MEM_W-1:0]  mem_addr
);
  always_comb begin
    case ({addr[MODE_BIT_A], addr[MODE_BIT_B]})
      2'b00:   mode = CM_INHIBIT;
      2'b01:   mode = CM_COPYBACK;
      default: mode = CM_WRTHRU;
    endcase
  end

  for (genvar i = 0; i < MEM_W; i++) begin : g_mirror
    assign mem_addr[i] = addr[src_bit(i, MODE_BIT_A, MODE_BIT_B)];
  end
endmodule

// File: rtl/cmg_table.sv
module cmg_table
  import cmg_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int TAG_W   = LINE_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] acc_idx,
  output logic             acc_vld,
  output logic [TAG_W-1:0] acc_tag,
  output cmode_e           acc_mode,
  input  logic [IDX_W-1:0] mnt_idx,
  output logic             mnt_vld,
  output logic [TAG_W-1:0] mnt_tag,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  input  cmode_e           set_mode,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem  [ENTRIES];
  cmode_e             mode_mem [ENTRIES];

  // Valid bits are separate flops so that reset clears them; the
  // tag and mode arrays stay reset-free.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (clr_en) valid_q[clr_idx] <= 1'b0;
      if (set_en) valid_q[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) begin
      tag_mem[set_idx]  <= set_tag;
      mode_mem[set_idx] <= set_mode;
    end
  end

  assign acc_vld  = valid_q[acc_idx];
  assign acc_tag  = tag_mem[acc_idx];
  assign acc_mode = mode_mem[acc_idx];
  assign mnt_vld  = valid_q[mnt_idx];
  assign mnt_tag  = tag_mem[mnt_idx];
endmodule

// File: rtl/cmg_policy.sv
module cmg_policy
  import cmg_pkg::*;
#(
  parameter int TAG_W = 22
) (
  input  logic             acc_valid,
  input  cmode_e           acc_mode,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             rec_vld,
  input  logic [TAG_W-1:0] rec_tag,
  input  cmode_e           rec_mode,
  input  logic             maint_same,
  output logic             viol_next,
  output logic             record
);
  logic hit;
  logic mixed;

  always_comb begin
    hit       = rec_vld && (rec_tag == acc_tag);
    mixed     = (acc_mode == CM_INHIBIT) && (rec_mode != CM_INHIBIT);
    viol_next = acc_valid && !maint_same && hit && mixed;
    record    = acc_valid && !maint_same && !viol_next;
  end
endmodule

// File: rtl/cmode_line_guard.sv
module cmode_line_guard
  import cmg_pkg::*;
#(
  parameter int MODE_BIT_A = 31,
  parameter int MODE_BIT_B = 30,
  parameter int ENTRIES    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic              maint_valid,
  input  logic [25:0]       maint_line,
  output cmode_e            mode_o,
  output logic [29:0]       mem_addr_o,
  output logic              viol_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = LINE_W - IDX_W;

  if (MODE_BIT_A == MODE_BIT_B || MODE_BIT_A < 24 || MODE_BIT_A > 31 ||
      MODE_BIT_B < 24 || MODE_BIT_B > 31) begin : g_bad_sel
    $error("mode selector bits must be distinct and within 31..24");
  end

  logic [LINE_W-1:0] acc_line;
  logic [IDX_W-1:0]  acc_idx, mnt_idx;
  logic [TAG_W-1:0]  acc_tag, mnt_tag_in;
  logic              rec_vld, mnt_vld;
  logic [TAG_W-1:0]  rec_tag, mnt_tag;
  cmode_e            rec_mode;
  logic              maint_same, maint_hit;
  logic              viol_next, record;
  logic              viol_q;

  cmg_decode #(.MODE_BIT_A(MODE_BIT_A), .MODE_BIT_B(MODE_BIT_B)) u_dec (
    .addr     (acc_addr),
    .mode     (mode_o),
    .mem_addr (mem_addr_o)
  );

  assign acc_line   = mem_addr_o[MEM_W-1:OFS_W];
  assign acc_idx    = acc_line[IDX_W-1:0];
  assign acc_tag    = acc_line[LINE_W-1:IDX_W];
  assign mnt_idx    = maint_line[IDX_W-1:0];
  assign mnt_tag_in = maint_line[LINE_W-1:IDX_W];
  assign maint_same = maint_valid && acc_valid && (maint_line == acc_line);
  assign maint_hit  = maint_valid && mnt_vld && (mnt_tag == mnt_tag_in);

  cmg_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tab (
    .clk      (clk),
    .rst      (rst),
    .acc_idx  (acc_idx),
    .acc_vld  (rec_vld),
    .acc_tag  (rec_tag),
    .acc_mode (rec_mode),
    .mnt_idx  (mnt_idx),
    .mnt_vld  (mnt_vld),
    .mnt_tag  (mnt_tag),
    .set_en   (record),
    .set_idx  (acc_idx),
    .set_tag  (acc_tag),
    .set_mode (mode_o),
    .clr_en   (maint_hit),
    .clr_idx  (mnt_idx)
  );

  cmg_policy #(.TAG_W(TAG_W)) u_pol (
    .acc_valid  (acc_valid),
    .acc_mode   (mode_o),
    .acc_tag    (acc_tag),
    .rec_vld    (rec_vld),
    .rec_tag    (rec_tag),
    .rec_mode   (rec_mode),
    .maint_same (maint_same),
    .viol_next  (viol_next),
    .record     (record)
  );

  always_ff @(posedge clk) begin
    if (rst) viol_q <= 1'b0;
    else     viol_q <= viol_next;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/cmg_guard_chk.sv
module cmg_guard_chk
  import cmg_pkg::*;
#(
  parameter int MODE_BIT_A = 31,
  parameter int MODE_BIT_B = 30
) (
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic [31:0] acc_addr,
  input logic        maint_valid,
  input logic [25:0] maint_line,
  input cmode_e      mode_o,
  input logic [29:0] mem_addr_o,
  input logic        viol_o
);
  // R1
  mode_wt_chk: assert property (@(posedge clk) disable iff (rst)
    acc_addr[MODE_BIT_A] |-> mode_o == CM_WRTHRU);

  // R1
  mode_inh_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_addr[MODE_BIT_A] && !acc_addr[MODE_BIT_B]) |-> mode_o == CM_INHIBIT);

  // R11
  viol_src_chk: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> $past(acc_valid));

  // R5
  viol_mode_chk: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> $past(mode_o) == CM_INHIBIT);

  // R9
  same_line_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && maint_valid && maint_line == mem_addr_o[29:4]) |=> !viol_o);

  // R10
  reset_clear_chk: assert property (@(posedge clk) rst |=> !viol_o);

  // R3
  always @(posedge clk) begin
    if (!rst) begin
      mirror_low_chk: assert (mem_addr_o[3:0] == acc_addr[3:0]);
    end
  end
endmodule

bind cmode_line_guard cmg_guard_chk #(
  .MODE_BIT_A(MODE_BIT_A),
  .MODE_BIT_B(MODE_BIT_B)
) u_chk (.*);

// File: tb/sim_cmode_line_guard.sv
module sim_cmode_line_guard;
  import cmg_pkg::*;
  localparam int MA  = 27;
  localparam int MB  = 25;
  localparam int ENT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        maint_valid = 1'b0;
  logic [25:0] maint_line = '0;
  cmode_e      mode_o;
  logic [29:0] mem_addr_o;
  logic        viol_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // Bench model of the tracking table.
  bit          m_vld  [ENT];
  logic [25:0] m_line [ENT];
  logic [1:0]  m_mode [ENT];

  cmode_line_guard #(.MODE_BIT_A(MA), .MODE_BIT_B(MB), .ENTRIES(ENT)) u0 (
    .clk, .rst, .acc_valid, .acc_addr, .maint_valid, .maint_line,
    .mode_o, .mem_addr_o, .viol_o
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk_addr(logic [25:0] line, logic [1:0] word,
                                          logic [1:0] code, logic [1:0] byt);
    logic [29:0] flat;
    logic [31:0] a;
    int k;
    flat = {line, word, byt};
    k = 0;
    for (int p = 0; p < 32; p++) begin
      if (p == MA)      a[p] = code[1];
      else if (p == MB) a[p] = code[0];
      else begin a[p] = flat[k]; k++; end
    end
    return a;
  endfunction

  function automatic logic [1:0] exp_mode(logic [1:0] code);
    return code[1] ? 2'd2 : code;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Entered and left at a falling edge.
  task automatic step(bit av, logic [1:0] code, logic [25:0] line, logic [1:0] word,
                      bit mv, logic [25:0] mline, string req);
    logic [31:0] a;
    logic [1:0]  md;
    int idx, midx;
    bit same, hit, ev;
    a = mk_addr(line, word, code, 2'($urandom));
    acc_valid = av; acc_addr = a; maint_valid = mv; maint_line = mline;
    #1;
    md = exp_mode(code);
    check(2'(mode_o) == md, "R1", "mode", 32'(mode_o), 32'(md));
    check(mem_addr_o == {line, word, a[1:0]}, "R3", "mirror", 32'(mem_addr_o),
          32'({line, word, a[1:0]}));
    idx  = int'(line % ENT);
    midx = int'(mline % ENT);
    same = mv && av && (mline == line);
    hit  = m_vld[idx] && m_line[idx] == line;
    ev   = av && !same && hit && (m_mode[idx] != 2'd0) && (md == 2'd0);
    if (mv && m_vld[midx] && m_line[midx] == mline) m_vld[midx] = 0;
    if (av && !same && !ev) begin
      m_vld[idx] = 1; m_line[idx] = line; m_mode[idx] = md;
    end
    @(posedge clk);
    @(negedge clk);
    check(viol_o == ev, req, "viol", 32'(viol_o), 32'(ev));
  endtask

  initial begin
    logic [25:0] l0, l1;
    void'($urandom(32'd4242));
    for (int i = 0; i < ENT; i++) m_vld[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(viol_o == 1'b0, "R10", "viol in reset", 32'(viol_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(viol_o == 1'b0, "R10", "viol after reset", 32'(viol_o), 0);

    l0 = 26'h0123450;
    l1 = 26'h0123451;
    // R10: inhibited access right after reset finds nothing tracked
    step(1, 2'b00, l0, 2'd0, 0, '0, "R10");
    // R4/R5: copyback on word 0, inhibited on word 3 of same line
    step(1, 2'b01, l0, 2'd0, 0, '0, "R4");
    step(1, 2'b00, l0, 2'd3, 0, '0, "R5");
    // R5: record unchanged, so a second inhibited access flags again
    step(1, 2'b00, l0, 2'd1, 0, '0, "R5");
    // R11: invalid access leaves no flag and no record
    step(0, 2'b00, l0, 2'd1, 0, '0, "R11");
    // R6: strobe clears the line, then inhibited is legal
    step(0, 2'b00, l0, 2'd0, 1, l0, "R6");
    step(1, 2'b00, l0, 2'd2, 0, '0, "R6");
    // R7: cachable on inhibited record, no flag, record becomes cachable
    step(1, 2'b11, l0, 2'd2, 0, '0, "R7");
    step(1, 2'b00, l0, 2'd2, 0, '0, "R7");
    // R8: eviction by a conflicting line makes l0 untracked
    step(1, 2'b10, l0 + 26'd8, 2'd0, 0, '0, "R8");
    step(1, 2'b00, l0, 2'd0, 0, '0, "R8");
    // R9: strobe and inhibited access to the same line together
    step(1, 2'b01, l1, 2'd0, 0, '0, "R9");
    step(1, 2'b00, l1, 2'd1, 1, l1, "R9");
    step(1, 2'b00, l1, 2'd1, 0, '0, "R9");
    // R2: non-adjacent selector positions, every code value
    for (int c = 0; c < 4; c++) step(1, 2'(c), l1 + 26'd2, 2'(c), 0, '0, "R2");

    for (int n = 0; n < 3000; n++) begin
      logic [25:0] ln, mln;
      ln  = 26'h0200000 + 26'($urandom % 12);
      mln = 26'h0200000 + 26'($urandom % 12);
      step(($urandom % 10) < 8, 2'($urandom), ln, 2'($urandom),
           ($urandom % 10) < 2, mln, "R5/R7/R8");
    end

    acc_valid = 0; maint_valid = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule